// File: doc/BRIEF.md
# Card Byte Stream to Word FIFO Engine

This block sits between a byte-wide card data port and a 16-entry FIFO of 32-bit words, and moves data in either direction. Software first loads a byte count. It then writes the control word, which holds a run bit and a direction bit, and that write starts the transfer. In the card-to-FIFO direction, incoming card bytes are packed little-endian into words and pushed into the FIFO, where the CPU pops them. In the FIFO-to-card direction, the CPU pushes words and the engine unpacks them, sending the low byte first. The engine moves at most one byte per clock, and the card side uses a valid/accept handshake.

The engine flushes a final partial word when the count runs out. It raises sticky end-of-transfer indications and turns itself off once the count is zero and the FIFO has drained. It also reports a set of FIFO occupancy flags for the active direction only.

Top module: `card_fifo_engine`

## Requirements
- R1: After reset the run bit, the remaining byte count, both end indications, both flag vectors, `cardRdAck` and `cardWrValid` are all zero.
- R2: A control write with `ctrlEnable`=1 copies the stored 16-bit length into the remaining byte count and clears both end indications. `ctrlDirRead`=1 selects card-to-FIFO and 0 selects FIFO-to-card.
- R3: In card-to-FIFO mode each accepted card byte decrements the count. Bytes are packed little-endian: the first byte of a group lands in bits 7:0 and the fourth in bits 31:24, and the completed word is pushed into the FIFO.
- R4: When the count reaches zero with 1 to 3 bytes collected, that partial word is pushed with its unused upper bytes zero.
- R5: In card-to-FIFO mode no card byte is accepted (`cardRdAck`=0) while the FIFO holds 16 words.
- R6: In FIFO-to-card mode a word leaves the FIFO only when the previous word's 4 bytes have all been sent. Bytes go out low byte first, one per `cardWrValid`/`cardWrReady` handshake.
- R7: One cycle after the count is zero with the run bit set, `dataEnd` and `blockEnd` both become 1 and stay set until the next start. The run bit clears once the count is zero and the FIFO is empty.
- R8: Flag vectors use bit 0 active, bit 1 empty (occupancy 0), bit 2 data available (occupancy nonzero) and bit 3 full (occupancy 16). Bit 4 is half-full (occupancy 8 or more) in `rxFlags` and half-empty (occupancy 8 or less) in `txFlags`. A vector is nonzero only while the run bit is set, the transfer is not finished (count or occupancy nonzero), and its direction is selected.
- R9: `wordsLeft` equals (remaining bytes + 3) / 4, rounded down.
- R10: A CPU push is discarded when the count is zero, when the FIFO is full, or in card-to-FIFO mode.
- R11: A CPU pop returns the head word and removes it, provided the FIFO is not empty and either card-to-FIFO mode is selected or the count is zero. Any other pop returns zero and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lenWrEn | input | 1 | Store `lenData` as the transfer length |
| lenData | input | 16 | Transfer length in bytes |
| ctrlWrEn | input | 1 | Control write strobe |
| ctrlEnable | input | 1 | Run bit written with the control word |
| ctrlDirRead | input | 1 | Direction: 1 card-to-FIFO, 0 FIFO-to-card |
| cpuPush | input | 1 | CPU pushes `cpuPushData` into the FIFO |
| cpuPushData | input | 32 | Word pushed by the CPU |
| cpuPop | input | 1 | CPU pops the FIFO head |
| cpuPopData | output | 32 | Popped word, zero when the pop is not serviced |
| cardRdValid | input | 1 | Card offers a byte |
| cardRdData | input | 8 | Byte offered by the card |
| cardRdAck | output | 1 | Offered card byte is taken this cycle |
| cardWrValid | output | 1 | Engine offers a byte to the card |
| cardWrData | output | 8 | Byte offered to the card |
| cardWrReady | input | 1 | Card takes the offered byte |
| xferEnable | output | 1 | Run bit |
| dataEnd | output | 1 | Sticky end-of-data indication |
| blockEnd | output | 1 | Sticky end-of-block indication |
| rxFlags | output | 5 | Card-to-FIFO occupancy flags |
| txFlags | output | 5 | FIFO-to-card occupancy flags |
| bytesLeft | output | 16 | Remaining byte count |
| wordsLeft | output | 15 | Remaining word count, rounded up |

## Verification
The bench goes after the last partial word of a 6-byte read. A design that drops it, or leaves stale bytes in the upper lanes, returns the wrong second word. It fills the FIFO to 16 during a 72-byte read to confirm that the card is stalled. A design that ignores fullness would overwrite the oldest word, and the popped stream would then break. On the write side, after three bytes have gone out, one more push must make the FIFO full again. An engine that popped a word per byte would show room left, and one that sent bytes high-first would scramble the byte stream. Further tests cover discarded pushes with a zero count and in read mode, an empty pop, a 0-byte start, and the direction masking of the flags; a wrong design there would show stale occupancy or flags on the wrong side.

// File: rtl/cfe_pkg.sv
package cfe_pkg;
  typedef struct packed {
    logic       rxTake;
    logic       rxPush;
    logic [1:0] rxLane;
    logic       txPop;
    logic       txShift;
    logic       txUseHead;
    logic       cpuPushAcc;
    logic       cpuPopAcc;
    logic       clrLanes;
  } cfe_strobe_t;
endpackage

// File: rtl/cfe_datapath.sv
module cfe_datapath
  import cfe_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int OCC_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cfe_strobe_t      stb,
  input  logic [7:0]       cardRdData,
  input  logic [31:0]      cpuPushData,
  output logic [OCC_W-1:0] occ,
  output logic [31:0]      cpuPopData,
  output logic [7:0]       cardWrData
);
  localparam int LANES = 4;

  logic [31:0]      mem [DEPTH];
  logic [PTR_W-1:0] rdPtr;
  logic [PTR_W-1:0] wrPtr;
  logic [31:0]      packReg;
  logic [31:0]      unpackReg;
  logic [31:0]      rxWord;
  logic [31:0]      headWord;
  logic [31:0]      pushVal;
  logic             pushEn;
  logic             popEn;

  // insert the incoming card byte into its lane of the partial word
  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign rxWord[g*8 +: 8] = (stb.rxLane == 2'(g)) ? cardRdData : packReg[g*8 +: 8];
  end

  assign wrPtr    = rdPtr + occ[PTR_W-1:0];
  assign headWord = mem[rdPtr];
  assign pushEn   = stb.rxPush | stb.cpuPushAcc;
  assign popEn    = stb.txPop | stb.cpuPopAcc;
  assign pushVal  = stb.rxPush ? rxWord : cpuPushData;

  always_ff @(posedge clk) begin
    if (pushEn) mem[wrPtr] <= pushVal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdPtr <= '0;
      occ   <= '0;
    end else begin
      if (popEn) rdPtr <= rdPtr + 1'b1;
      case ({pushEn, popEn})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      packReg <= '0;
    end else if (stb.clrLanes) begin
      packReg <= '0;
    end else if (stb.rxTake) begin
      packReg <= stb.rxPush ? '0 : rxWord;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unpackReg <= '0;
    end else if (stb.txPop) begin
      unpackReg <= headWord >> 8;
    end else if (stb.txShift) begin
      unpackReg <= unpackReg >> 8;
    end
  end

  assign cardWrData = stb.txUseHead ? headWord[7:0] : unpackReg[7:0];
  assign cpuPopData = stb.cpuPopAcc ? headWord : 32'h0;
endmodule

// File: rtl/cfe_control.sv
module cfe_control
  import cfe_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LEN_W = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int OCC_W = PTR_W + 1,
  localparam int HALF  = DEPTH / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lenWrEn,
  input  logic [LEN_W-1:0] lenData,
  input  logic             ctrlWrEn,
  input  logic             ctrlEnable,
  input  logic             ctrlDirRead,
  input  logic             cpuPush,
  input  logic             cpuPop,
  input  logic             cardRdValid,
  input  logic             cardWrReady,
  input  logic [OCC_W-1:0] occ,
  output cfe_strobe_t      stb,
  output logic             cardRdAck,
  output logic             cardWrValid,
  output logic             xferEnable,
  output logic             dataEnd,
  output logic             blockEnd,
  output logic [4:0]       rxFlags,
  output logic [4:0]       txFlags,
  output logic [LEN_W-1:0] bytesLeft,
  output logic [LEN_W-2:0] wordsLeft
);
  logic [LEN_W-1:0] lenReg;
  logic [LEN_W-1:0] cnt;
  logic             enable;
  logic             dirRead;
  logic [1:0]       rxLane;
  logic [1:0]       txLeft;
  logic             full;
  logic             empty;
  logic             cntZero;
  logic             rxTake;
  logic             txGo;
  logic             txFire;
  logic             busy;
  logic [3:0]       baseFlags;
  logic [LEN_W:0]   wordSum;

  always_comb begin
    full    = (occ == OCC_W'(DEPTH));
    empty   = (occ == '0);
    cntZero = (cnt == '0);
    rxTake  = 1'b0;
    txGo    = 1'b0;
    txFire  = 1'b0;
    stb     = '0;
    stb.rxLane    = rxLane;
    stb.txUseHead = (txLeft == 2'd0);
    stb.clrLanes  = ctrlWrEn & ctrlEnable;
    if (!ctrlWrEn) begin
      rxTake = enable & dirRead & ~cntZero & cardRdValid & ~full;
      txGo   = enable & ~dirRead & ~cntZero & ((txLeft != 2'd0) | ~empty);
      txFire = txGo & cardWrReady;
      stb.rxTake     = rxTake;
      stb.rxPush     = rxTake & ((rxLane == 2'd3) | (cnt == LEN_W'(1)));
      stb.txPop      = txFire & (txLeft == 2'd0);
      stb.txShift    = txFire & (txLeft != 2'd0);
      stb.cpuPushAcc = cpuPush & ~dirRead & ~cntZero & ~full;
      stb.cpuPopAcc  = cpuPop & ~empty & (dirRead | cntZero);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lenReg   <= '0;
      cnt      <= '0;
      enable   <= 1'b0;
      dirRead  <= 1'b0;
      rxLane   <= 2'd0;
      txLeft   <= 2'd0;
      dataEnd  <= 1'b0;
      blockEnd <= 1'b0;
    end else begin
      if (lenWrEn) lenReg <= lenData;
      if (ctrlWrEn) begin
        dirRead <= ctrlDirRead;
        enable  <= ctrlEnable;
        if (ctrlEnable) begin
          cnt      <= lenReg;
          rxLane   <= 2'd0;
          txLeft   <= 2'd0;
          dataEnd  <= 1'b0;
          blockEnd <= 1'b0;
        end
      end else begin
        if (rxTake | txFire) cnt <= cnt - 1'b1;
        if (rxTake) rxLane <= stb.rxPush ? 2'd0 : rxLane + 2'd1;
        if (stb.txPop) txLeft <= 2'd3;
        else if (stb.txShift) txLeft <= txLeft - 2'd1;
        if (enable && cntZero) begin
          dataEnd  <= 1'b1;
          blockEnd <= 1'b1;
          if (empty) enable <= 1'b0;
        end
      end
    end
  end

  assign busy      = enable & ~(cntZero & empty);
  assign baseFlags = {full, ~empty, empty, 1'b1};
  assign rxFlags   = (busy & dirRead)  ? {occ >= OCC_W'(HALF), baseFlags} : 5'b0;
  assign txFlags   = (busy & ~dirRead) ? {occ <= OCC_W'(HALF), baseFlags} : 5'b0;

  assign wordSum     = {1'b0, cnt} + (LEN_W+1)'(3);
  assign wordsLeft   = wordSum[LEN_W:2];
  assign bytesLeft   = cnt;
  assign xferEnable  = enable;
  assign cardRdAck   = rxTake;
  assign cardWrValid = txGo;
endmodule

// File: rtl/card_fifo_engine.sv
module card_fifo_engine
  import cfe_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lenWrEn,
  input  logic [LEN_W-1:0] lenData,
  input  logic             ctrlWrEn,
  input  logic             ctrlEnable,
  input  logic             ctrlDirRead,
  input  logic             cpuPush,
  input  logic [31:0]      cpuPushData,
  input  logic             cpuPop,
  output logic [31:0]      cpuPopData,
  input  logic             cardRdValid,
  input  logic [7:0]       cardRdData,
  output logic             cardRdAck,
  output logic             cardWrValid,
  output logic [7:0]       cardWrData,
  input  logic             cardWrReady,
  output logic             xferEnable,
  output logic             dataEnd,
  output logic             blockEnd,
  output logic [4:0]       rxFlags,
  output logic [4:0]       txFlags,
  output logic [LEN_W-1:0] bytesLeft,
  output logic [LEN_W-2:0] wordsLeft
);
  localparam int OCC_W = $clog2(DEPTH) + 1;

  cfe_strobe_t      stb;
  logic [OCC_W-1:0] occ;

  cfe_control #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .lenWrEn(lenWrEn), .lenData(lenData),
    .ctrlWrEn(ctrlWrEn), .ctrlEnable(ctrlEnable), .ctrlDirRead(ctrlDirRead),
    .cpuPush(cpuPush), .cpuPop(cpuPop),
    .cardRdValid(cardRdValid), .cardWrReady(cardWrReady),
    .occ(occ), .stb(stb),
    .cardRdAck(cardRdAck), .cardWrValid(cardWrValid),
    .xferEnable(xferEnable), .dataEnd(dataEnd), .blockEnd(blockEnd),
    .rxFlags(rxFlags), .txFlags(txFlags),
    .bytesLeft(bytesLeft), .wordsLeft(wordsLeft)
  );

  cfe_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb),
    .cardRdData(cardRdData), .cpuPushData(cpuPushData),
    .occ(occ), .cpuPopData(cpuPopData), .cardWrData(cardWrData)
  );
endmodule

// File: rtl/card_fifo_engine_chk.sv
module card_fifo_engine_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctrlWrEn,
  input logic             cardRdValid,
  input logic             cardRdAck,
  input logic             cardWrValid,
  input logic             xferEnable,
  input logic             dataEnd,
  input logic             blockEnd,
  input logic [4:0]       rxFlags,
  input logic [4:0]       txFlags,
  input logic [LEN_W-1:0] bytesLeft
);
  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(rxFlags[0] && txFlags[0])); // R8

  AST_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !(rxFlags[3] && rxFlags[1]) && !(txFlags[3] && txFlags[1])); // R8

  AST_COUNT_MONOTONE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrlWrEn |=> bytesLeft <= $past(bytesLeft)); // R3

  AST_NO_TAKE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    rxFlags[3] |-> !cardRdAck); // R5

  AST_TAKE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    cardRdAck |-> cardRdValid && rxFlags[0]); // R3

  AST_SEND_NEEDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    cardWrValid |-> (bytesLeft != '0) && txFlags[0]); // R6

  AST_END_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    dataEnd == blockEnd); // R7

  AST_STOP_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(xferEnable) && !$past(ctrlWrEn)) |-> ($past(bytesLeft) == '0)); // R7
endmodule

bind card_fifo_engine card_fifo_engine_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrlWrEn(ctrlWrEn),
  .cardRdValid(cardRdValid), .cardRdAck(cardRdAck), .cardWrValid(cardWrValid),
  .xferEnable(xferEnable), .dataEnd(dataEnd), .blockEnd(blockEnd),
  .rxFlags(rxFlags), .txFlags(txFlags), .bytesLeft(bytesLeft)
);

// File: tb/sim_card_fifo_engine.sv
module sim_card_fifo_engine;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lenWrEn = 1'b0;
  logic [15:0] lenData = '0;
  logic        ctrlWrEn = 1'b0;
  logic        ctrlEnable = 1'b0;
  logic        ctrlDirRead = 1'b0;
  logic        cpuPush = 1'b0;
  logic [31:0] cpuPushData = '0;
  logic        cpuPop = 1'b0;
  logic [31:0] cpuPopData;
  logic        cardRdValid = 1'b0;
  logic [7:0]  cardRdData = '0;
  logic        cardRdAck;
  logic        cardWrValid;
  logic [7:0]  cardWrData;
  logic        cardWrReady = 1'b0;
  logic        xferEnable, dataEnd, blockEnd;
  logic [4:0]  rxFlags, txFlags;
  logic [15:0] bytesLeft;
  logic [14:0] wordsLeft;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // card byte source and sink state, changed by the main flow between edges
  bit  srcOn = 1'b0;
  int  srcIdx = 0;
  int  srcLen = 0;
  bit  sinkOn = 1'b0;
  int  sinkCnt = 0;
  int  sinkMax = 0;
  logic [7:0] sinkBuf [0:127];

  card_fifo_engine u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] srcByte(int k);
    return 8'((k * 7 + 3) & 255);
  endfunction

  function automatic logic [31:0] txWord(int i);
    return {8'(4*i+3) ^ 8'h5A, 8'(4*i+2) ^ 8'h5A, 8'(4*i+1) ^ 8'h5A, 8'(4*i) ^ 8'h5A};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // card source: offers bytes, counts those taken
  initial begin
    forever begin
      bit took;
      @(negedge clk);
      cardRdValid = srcOn && (srcIdx < srcLen);
      cardRdData  = srcByte(srcIdx);
      #1 took = cardRdAck;
      @(posedge clk);
      if (took) srcIdx++;
    end
  end

  // card sink: accepts bytes up to sinkMax
  initial begin
    forever begin
      bit took;
      logic [7:0] b;
      @(negedge clk);
      cardWrReady = sinkOn && (sinkCnt < sinkMax);
      #1 took = cardWrReady && cardWrValid;
      b = cardWrData;
      @(posedge clk);
      if (took) begin
        sinkBuf[sinkCnt] = b;
        sinkCnt++;
      end
    end
  end

  task automatic waitCycles(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic setLen(int len);
    @(negedge clk); lenWrEn = 1'b1; lenData = 16'(len);
    @(posedge clk); #1 lenWrEn = 1'b0;
  endtask

  task automatic ctrlWrite(bit en, bit dirRd);
    @(negedge clk); ctrlWrEn = 1'b1; ctrlEnable = en; ctrlDirRead = dirRd;
    @(posedge clk); #1 ctrlWrEn = 1'b0;
  endtask

  task automatic pushWord(logic [31:0] d);
    @(negedge clk); cpuPush = 1'b1; cpuPushData = d;
    @(posedge clk); #1 cpuPush = 1'b0;
  endtask

  task automatic popWord(output logic [31:0] d);
    int w = 0;
    @(negedge clk);
    while (!rxFlags[2] && w < 100) begin @(negedge clk); w++; end
    cpuPop = 1'b1;
    #1 d = cpuPopData;
    @(posedge clk); #1 cpuPop = 1'b0;
  endtask

  task automatic testReset();
    #1;
    check("R1 enable", 32'(xferEnable), 0);
    check("R1 count", 32'(bytesLeft), 0);
    check("R1 ends", {dataEnd, blockEnd}, 0);
    check("R1 flags", {rxFlags, txFlags}, 0);
    check("R1 card strobes", {cardRdAck, cardWrValid}, 0);
  endtask

  task automatic testReadShort();
    logic [31:0] d;
    setLen(6);
    ctrlWrite(1'b1, 1'b1);
    waitCycles(1);
    check("R2 length loaded", 32'(bytesLeft), 6);
    check("R9 words rounded up", 32'(wordsLeft), 2);
    pushWord(32'hDEADBEEF);                         // R10 read direction
    waitCycles(1);
    check("R10 push ignored in read mode", 32'(rxFlags), 32'h03);
    check("R8 tx side masked", 32'(txFlags), 0);
    srcIdx = 0; srcLen = 6; srcOn = 1'b1;
    waitCycles(14);
    check("R3 count drained", 32'(bytesLeft), 0);
    check("R8 two words held", 32'(rxFlags), 32'h05);
    check("R7 end flags set", {dataEnd, blockEnd}, 32'h3);
    popWord(d);
    check("R3 little-endian word", d, {srcByte(3), srcByte(2), srcByte(1), srcByte(0)});
    popWord(d);
    check("R4 partial word", d, {16'h0, srcByte(5), srcByte(4)});
    srcOn = 1'b0;
    waitCycles(3);
    check("R7 idle after drain", 32'(xferEnable), 0);
    check("R8 flags clear when idle", 32'(rxFlags), 0);
    @(negedge clk); cpuPop = 1'b1;
    #1 check("R11 empty pop returns zero", cpuPopData, 0);
    @(posedge clk); #1 cpuPop = 1'b0;
  endtask

  task automatic testReadFull();
    logic [31:0] d;
    setLen(72);
    ctrlWrite(1'b1, 1'b1);
    srcIdx = 0; srcLen = 72; srcOn = 1'b1;
    waitCycles(90);
    check("R8 full flags", 32'(rxFlags), 32'h1D);
    check("R5 count stalled", 32'(bytesLeft), 8);
    check("R9 words left", 32'(wordsLeft), 2);
    @(negedge clk); #1;
    check("R5 no take when full", {cardRdValid, cardRdAck}, 32'h2);
    for (int i = 0; i < 18; i++) begin
      popWord(d);
      check("R5 stream order", d,
            {srcByte(4*i+3), srcByte(4*i+2), srcByte(4*i+1), srcByte(4*i)});
    end
    srcOn = 1'b0;
    waitCycles(3);
    check("R7 read idle", 32'(xferEnable), 0);
  endtask

  task automatic testWrite();
    int w;
    bit ok;
    logic [31:0] d;
    sinkOn = 1'b0; sinkCnt = 0; sinkMax = 0;
    setLen(70);
    ctrlWrite(1'b1, 1'b0);
    waitCycles(1);
    check("R8 tx empty flags", 32'(txFlags), 32'h13);
    check("R2 ends cleared by start", {dataEnd, blockEnd}, 0);
    for (int i = 0; i < 16; i++) pushWord(txWord(i));
    waitCycles(1);
    check("R8 tx full flags", 32'(txFlags), 32'h0D);
    @(negedge clk); cpuPop = 1'b1;
    #1 d = cpuPopData;
    @(posedge clk); #1 cpuPop = 1'b0;
    check("R11 pop refused in write mode", d, 0);
    pushWord(32'hBAD0BAD0);                         // R10 full
    waitCycles(1);
    check("R11 R10 still full", 32'(txFlags), 32'h0D);
    sinkMax = 3; sinkOn = 1'b1;
    waitCycles(10);
    check("R6 three bytes sent", 32'(sinkCnt), 3);
    check("R6 one word taken", 32'(txFlags), 32'h05);
    pushWord(txWord(16));
    waitCycles(1);
    check("R6 no early pop", 32'(txFlags), 32'h0D);
    sinkMax = 1000;
    w = 0;
    @(negedge clk);
    while (txFlags[3] && w < 200) begin @(negedge clk); w++; end
    pushWord(txWord(17));
    w = 0;
    while (xferEnable && w < 300) begin @(posedge clk); w++; end
    #2;
    check("R6 byte total", 32'(sinkCnt), 70);
    ok = 1'b1;
    for (int j = 0; j < 70; j++) if (sinkBuf[j] !== (8'(j) ^ 8'h5A)) ok = 1'b0;
    check("R6 low byte first order", 32'(ok), 1);
    check("R7 write ends set", {dataEnd, blockEnd}, 32'h3);
    check("R8 tx flags idle", 32'(txFlags), 0);
    sinkOn = 1'b0;
  endtask

  task automatic testZeroCountPush();
    pushWord(32'h12345678);                         // R10 count is zero
    setLen(4);
    ctrlWrite(1'b1, 1'b0);
    waitCycles(1);
    check("R10 zero-count push discarded", 32'(txFlags), 32'h13);
    ctrlWrite(1'b0, 1'b0);
  endtask

  task automatic testZeroLength();
    setLen(0);
    ctrlWrite(1'b1, 1'b1);
    #1 check("R2 start clears ends", {dataEnd, blockEnd}, 0);
    waitCycles(2);
    check("R7 zero length ends", {dataEnd, blockEnd}, 32'h3);
    check("R7 zero length idle", 32'(xferEnable), 0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=complete");
      summary();
      $finish;
    end
  end

  initial begin
    testReset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    testReset();
    testReadShort();
    testReadFull();
    testWrite();
    testZeroCountPush();
    testZeroLength();
    if (!finished) begin
      finished = 1'b1;
      summary();
      $finish;
    end
  end
endmodule